// File: doc/BRIEF.md
# Zero-Cross Gain Update Controller

This block decides when a newly written 7-bit gain code reaches each channel of a stereo input amplifier. Code 0x00 is mute and 0x60 is the top of the 97-step range. A write can take effect at once on every channel, or it can arm the channels. An armed channel then waits for the next sign change of its own audio samples, so the step in gain falls near a zero of the waveform and does not make an audible click.

A shared timer counts sample-rate ticks from the last armed write. When a channel sees no sign change within the selected window, the timer forces it to commit. Each channel commits on its own. A second write that arrives before both channels have finished restarts the timer and retargets both channels. For a while, the left and right codes can therefore differ.

Top module: `zc_gain_ctrl`

## Requirements
- R1: While reset is held and after it is released, both applied gain codes read 0x00 and both done flags read 1.
- R2: With `zc_en` = 0, a write puts `wr_gain` unchanged into every channel at the clock edge that samples `wr_en`, and sets every done flag. This holds for every code from 0x00 to 0x60.
- R3: With `adc_pwr` = 0, `zc_en` is ignored and every write applies immediately, as in R2.
- R4: With `zc_en` = 1 and `adc_pwr` = 1, a write clears every done flag at the sampling edge and leaves the applied codes unchanged until each channel commits.
- R5: Bit i of `sign_in` is the sign of channel i (1 = negative). Channel 0 is `gain_out[6:0]` and channel 1 is `gain_out[13:7]`. On a tick where that sign differs from the sign seen at the channel's previous tick (taken as 0 after reset), a waiting channel adopts the last written code and sets its done flag. The other channel is not affected.
- R6: `tmo_sel` value s gives a window of 256·2^s ticks. Channels still waiting commit on the tick that completes that many ticks since the arming write.
- R7: An armed write that arrives before completion re-arms both channels and restarts the window. A channel that had already committed keeps its code until it commits again, so the two codes can differ.
- R8: The timer advances only on `fs_tick`. Clock cycles without a tick do not shorten the window. Without a write or a tick, neither the codes nor the done flags change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fs_tick | input | 1 | One-cycle pulse per audio sample |
| sign_in | input | 2 | Per-channel sample sign, valid with `fs_tick` |
| wr_en | input | 1 | Gain write strobe |
| wr_gain | input | 7 | Gain code written |
| zc_en | input | 1 | Enables zero-cross / timeout deferral |
| tmo_sel | input | 2 | Timeout window select |
| adc_pwr | input | 1 | Converter power; 0 forces immediate update |
| gain_out | output | 14 | Applied code per channel, channel 0 in the low bits |
| done | output | 2 | Per-channel commit flag |

## Verification
The assertions assume that `fs_tick` is a single-cycle pulse and that `sign_in` is only meaningful while it is high. They also assume that a write and a tick may coincide, in which case the write wins. The stimulus drives every input on the falling clock edge and never holds `fs_tick` for two consecutive cycles. Sign bits change only together with a tick. Written codes stay inside 0x00..0x60.

// File: rtl/zc_gain_pkg.sv
package zc_gain_pkg;
  // Number of sample ticks in a timeout window for a given select code.
  function automatic int unsigned tmo_ticks(input logic [1:0] sel, input int unsigned base);
    return base << sel;
  endfunction

  // A crossing is a sign change between two consecutive samples.
  function automatic logic sign_flip(input logic prev_s, input logic cur_s);
    return prev_s ^ cur_s;
  endfunction
endpackage

// File: rtl/zc_tmo_timer.sv
module zc_tmo_timer #(
  parameter int unsigned TMO_BASE = 256,
  parameter int unsigned CW       = $clog2(TMO_BASE * 8)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fs_tick,
  input  logic          restart,
  input  logic          pend_any,
  input  logic [1:0]    tmo_sel,
  output logic          tmo_hit,
  output logic [CW-1:0] cnt
);
  import zc_gain_pkg::*;
  localparam int unsigned LW = CW + 1;

  logic [LW-1:0] lim;

  always_comb begin
    lim     = LW'(tmo_ticks(tmo_sel, TMO_BASE));
    tmo_hit = pend_any && fs_tick && !restart && ({1'b0, cnt} >= lim - LW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (restart)          cnt <= '0;
    else if (pend_any && fs_tick)
      cnt <= tmo_hit ? '0 : cnt + CW'(1);
  end
endmodule

// File: rtl/zc_lane.sv
module zc_lane #(
  parameter int unsigned GW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fs_tick,
  input  logic          sign_s,
  input  logic          wr_imm,
  input  logic          wr_arm,
  input  logic [GW-1:0] wr_gain,
  input  logic [GW-1:0] target,
  input  logic          tmo_hit,
  output logic [GW-1:0] gain,
  output logic          pending,
  output logic          zc_hit
);
  import zc_gain_pkg::*;

  logic prev_s;

  assign zc_hit = fs_tick && sign_flip(prev_s, sign_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prev_s <= 1'b0;
    else if (fs_tick) prev_s <= sign_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain    <= '0;
      pending <= 1'b0;
    end else if (wr_imm) begin
      gain    <= wr_gain;
      pending <= 1'b0;
    end else if (wr_arm) begin
      pending <= 1'b1;
    end else if (pending && (zc_hit || tmo_hit)) begin
      gain    <= target;
      pending <= 1'b0;
    end
  end
endmodule

// File: rtl/zc_gain_ctrl.sv
module zc_gain_ctrl #(
  parameter int unsigned NCH      = 2,
  parameter int unsigned GW       = 7,
  parameter int unsigned TMO_BASE = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs_tick,
  input  logic [NCH-1:0]    sign_in,
  input  logic              wr_en,
  input  logic [GW-1:0]     wr_gain,
  input  logic              zc_en,
  input  logic [1:0]        tmo_sel,
  input  logic              adc_pwr,
  output logic [NCH*GW-1:0] gain_out,
  output logic [NCH-1:0]    done
);
  localparam int unsigned CW = $clog2(TMO_BASE * 8);

  logic          wr_imm;
  logic          wr_arm;
  logic          tmo_hit;
  logic          pend_any;
  logic [CW-1:0] tmr_cnt;
  logic [NCH-1:0] pend;
  logic [NCH-1:0] zc_hit;
  logic [GW-1:0]  target;

  assign wr_arm   = wr_en && zc_en && adc_pwr;
  assign wr_imm   = wr_en && !(zc_en && adc_pwr);
  assign pend_any = |pend;
  assign done     = ~pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     target <= '0;
    else if (wr_en) target <= wr_gain;
  end

  zc_tmo_timer #(.TMO_BASE(TMO_BASE), .CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .fs_tick(fs_tick), .restart(wr_arm),
    .pend_any(pend_any), .tmo_sel(tmo_sel), .tmo_hit(tmo_hit), .cnt(tmr_cnt)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_lane
    zc_lane #(.GW(GW)) u_lane (
      .clk(clk), .rst_n(rst_n), .fs_tick(fs_tick), .sign_s(sign_in[i]),
      .wr_imm(wr_imm), .wr_arm(wr_arm), .wr_gain(wr_gain), .target(target),
      .tmo_hit(tmo_hit), .gain(gain_out[i*GW +: GW]), .pending(pend[i]),
      .zc_hit(zc_hit[i])
    );
  end
endmodule

// File: rtl/zc_gain_ctrl_chk.sv
module zc_gain_ctrl_chk #(
  parameter int unsigned NCH = 2,
  parameter int unsigned GW  = 7,
  parameter int unsigned CW  = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fs_tick,
  input logic              wr_en,
  input logic [GW-1:0]     wr_gain,
  input logic              adc_pwr,
  input logic [NCH*GW-1:0] gain_out,
  input logic [NCH-1:0]    done,
  input logic              wr_imm,
  input logic              wr_arm,
  input logic [NCH-1:0]    zc_hit,
  input logic              tmo_hit,
  input logic [CW-1:0]     tmr_cnt
);
  assert_arm_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_arm |=> (done == '0) && $stable(gain_out));

  assert_timeout_all_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> (&done));

  assert_quiet_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !fs_tick) |=> ($stable(gain_out) && $stable(done)));

  assert_timer_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((&done) && !wr_en) |=> $stable(tmr_cnt));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assert_imm_apply_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_imm |=> (gain_out[i*GW +: GW] == $past(wr_gain)) && done[i]);

    assert_unpowered_imm_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !adc_pwr) |=> done[i] && (gain_out[i*GW +: GW] == $past(wr_gain)));

    assert_cross_commits_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!done[i] && !wr_en && zc_hit[i]) |=> done[i]);

    assert_committed_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done[i] && !wr_en) |=> $stable(gain_out[i*GW +: GW]));
  end
endmodule

bind zc_gain_ctrl zc_gain_ctrl_chk #(.NCH(NCH), .GW(GW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fs_tick(fs_tick), .wr_en(wr_en), .wr_gain(wr_gain),
  .adc_pwr(adc_pwr), .gain_out(gain_out), .done(done), .wr_imm(wr_imm),
  .wr_arm(wr_arm), .zc_hit(zc_hit), .tmo_hit(tmo_hit), .tmr_cnt(tmr_cnt)
);

// File: tb/zc_gain_ctrl_bench.sv
module zc_gain_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fs_tick = 1'b0;
  logic [1:0]  sign_in = 2'b00;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_gain = '0;
  logic        zc_en = 1'b0;
  logic [1:0]  tmo_sel = 2'b11;
  logic        adc_pwr = 1'b1;
  logic [13:0] gain_out;
  logic [1:0]  done;

  int total = 0;
  int bad = 0;
  int c0 = 0;
  int c1 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zc_gain_ctrl u_zc_gain_ctrl (
    .clk(clk), .rst_n(rst_n), .fs_tick(fs_tick), .sign_in(sign_in), .wr_en(wr_en),
    .wr_gain(wr_gain), .zc_en(zc_en), .tmo_sel(tmo_sel), .adc_pwr(adc_pwr),
    .gain_out(gain_out), .done(done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag, input int e0, input int e1, input int ed);
    chk(tag, int'(gain_out[6:0]), e0);
    chk(tag, int'(gain_out[13:7]), e1);
    chk(tag, int'(done), ed);
  endtask

  task automatic wr(input logic [6:0] g);
    @(negedge clk);
    wr_en = 1'b1;
    wr_gain = g;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tk(input logic [1:0] s);
    @(negedge clk);
    fs_tick = 1'b1;
    sign_in = s;
    @(negedge clk);
    fs_tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_state("R1 in reset", int'(gain_out[6:0]) | 0, int'(gain_out[13:7]) | 0, 3);
    chk("R1 in reset gain", int'(gain_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_state("R1 after reset", 0, 0, 3);

    // R2: immediate path, sweep every legal code
    zc_en = 1'b0;
    for (int g = 0; g <= 'h60; g++) begin
      wr(7'(g));
      chk_state("R2 immediate", g, g, 3);
    end

    // R3: power off overrides zero-cross enable
    zc_en = 1'b1;
    adc_pwr = 1'b0;
    wr(7'h25); chk_state("R3 unpowered", 'h25, 'h25, 3);
    wr(7'h00); chk_state("R3 unpowered", 0, 0, 3);
    wr(7'h40); chk_state("R3 unpowered", 'h40, 'h40, 3);

    // R4/R5: armed write, per-channel crossings
    adc_pwr = 1'b1;
    tmo_sel = 2'b11;
    wr(7'h30); chk_state("R4 armed hold", 'h40, 'h40, 0);
    tk(2'b00); chk_state("R5 no flip", 'h40, 'h40, 0);
    tk(2'b01); chk_state("R5 ch0 flips", 'h30, 'h40, 1);
    tk(2'b01); chk_state("R5 steady", 'h30, 'h40, 1);
    tk(2'b11); chk_state("R5 ch1 flips", 'h30, 'h30, 3);

    // R7: channels diverge after a rewrite
    wr(7'h31); chk_state("R4 armed hold", 'h30, 'h30, 0);
    tk(2'b10); chk_state("R5 ch0 only", 'h31, 'h30, 1);
    wr(7'h32); chk_state("R7 diverged", 'h31, 'h30, 0);
    for (int n = 0; n < BASE*8 - 1; n++) tk(2'b10);
    chk_state("R6 sel3 before window", 'h31, 'h30, 0);
    tk(2'b10); chk_state("R6 sel3 window end", 'h32, 'h32, 3);
    c0 = 'h32; c1 = 'h32;

    // R6: remaining window lengths
    for (int s = 0; s < 3; s++) begin
      tmo_sel = 2'(s);
      wr(7'('h50 + s));
      for (int n = 0; n < (BASE << s) - 1; n++) tk(2'b10);
      chk_state("R6 before window", c0, c1, 0);
      tk(2'b10);
      chk_state("R6 window end", 'h50 + s, 'h50 + s, 3);
      c0 = 'h50 + s; c1 = 'h50 + s;
    end

    // R8: cycles without ticks do not count
    tmo_sel = 2'b00;
    wr(7'h05);
    repeat (300) @(negedge clk);
    chk_state("R8 idle cycles", c0, c1, 0);
    for (int n = 0; n < BASE - 1; n++) tk(2'b10);
    chk_state("R8 window intact", c0, c1, 0);
    tk(2'b10); chk_state("R8 commit", 5, 5, 3);

    // R7: rewrite restarts the window
    wr(7'h06);
    for (int n = 0; n < 100; n++) tk(2'b10);
    wr(7'h07); chk_state("R7 rearm", 5, 5, 0);
    for (int n = 0; n < BASE - 1; n++) tk(2'b10);
    chk_state("R7 restarted window", 5, 5, 0);
    tk(2'b10); chk_state("R7 commit new target", 7, 7, 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule